// File: doc/BRIEF.md
# Dual-Space I2C Register-File Target

This block is a two-wire serial target that a system-clock domain uses to expose two banks of byte registers to an external I2C controller. It answers to two 7-bit device identifiers. One selects a control/status bank and the other a separate user bank. Each bank holds 48 bytes at word addresses 00h to 2Fh.

A single internal word pointer is shared by both banks. The controller loads it with an address byte after a write-direction identifier. Data can then be written one byte per transfer, or read back with a repeated START. A read with no address byte starts wherever the pointer was left. Reads go on while the controller acknowledges each byte, and the pointer steps by one per byte sent, wrapping from 2Fh to 00h.

SCL and SDA are sampled by the much faster system clock. START and STOP are recognised from the sampled lines. The block pulls SDA low only through an open-drain enable, and it never drives or stretches SCL.

Top module: `i2c_dual_regfile`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0) and the word pointer is 00h. A read transfer with no address byte therefore returns location 00h first, then 01h. Bank contents are not cleared by reset.
- R2: A first byte after START whose upper seven bits are 1101111 selects the control/status bank, and one whose upper seven bits are 1010111 selects the user bank. Bit 0 of that byte is the direction: 1 is read and 0 is write. The target acknowledges either identifier by pulling SDA low in the ninth clock. The two banks are independent storage, so the same address in each bank holds its own value.
- R3: A first byte whose identifier matches neither value is not acknowledged. SDA then stays released for every later clock until the next START or STOP.
- R4: A write transfer is an identifier with direction 0, an address byte and one data byte, each acknowledged. The data is stored at that address. Any further data byte in the same transfer is not acknowledged and is not stored.
- R5: In a random read, the address byte is followed by a repeated START and a read identifier, and data then comes from the given address. If the identifier after the repeated START differs from the one before it, the read identifier is not acknowledged.
- R6: During a read, the target sends the byte at the pointer, and the pointer advances by one for each byte sent. After 2Fh it wraps to 00h, and sending continues while the controller acknowledges in the ninth clock.
- R7: A NACK from the controller after a read byte ends the read. The target keeps SDA released, and the pointer is left one past the last byte sent, with wrap applied.
- R8: An address byte above 2Fh is acknowledged, and so is the data byte that follows it. The write is discarded. A read from such an address returns 00h, after which the pointer continues at 00h.
- R9: A START or STOP at any bit position aborts the byte in progress and clears the bit count. The next transfer then proceeds normally.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After an acknowledge, the target releases SDA once the ninth clock ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it to the pull-up |

## Verification
The pointer step taken in the ninth clock of a read byte can fall in the same cycle as the controller's NACK that ends the read. If both occur at location 2Fh, the wrap and the end of the transfer land on one edge. The bench provokes this with a random read at 2Fh that is NACKed after its first byte. It judges the result by the data of a following read with no address byte, which must come from location 00h.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ID,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;

  // Pointer step with wrap after the last implemented location.
  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p,
                                                 input logic [BYTE_W-1:0] last);
    return (p >= last) ? '0 : p + 1'b1;
  endfunction

  // Identifier acceptance: either id is known, but a read after an address
  // byte within the same transfer must repeat the previous identifier.
  function automatic logic id_accept(input logic [BYTE_W-1:0] b,
                                     input logic              after_addr,
                                     input logic [6:0]        prev,
                                     input logic [6:0]        id_a,
                                     input logic [6:0]        id_b);
    logic known;
    known = (b[7:1] == id_a) || (b[7:1] == id_b);
    if (after_addr && b[0] && (b[7:1] != prev)) return 1'b0;
    return known;
  endfunction

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rf_bank.sv
module i2c_rf_bank #(
  parameter int unsigned DEPTH = 48
) (
  input  logic       clk,
  input  logic       wr_en,
  input  logic       wr_space,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_space,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data
);

  localparam int unsigned SPACES = 2;
  localparam int unsigned IW     = $clog2(DEPTH);
  localparam logic [7:0]  DEPTH_B = 8'(DEPTH);

  logic [7:0] rd_vec [SPACES];

  for (genvar g = 0; g < SPACES; g++) begin : g_space
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_space == 1'(g))) mem[wr_addr[IW-1:0]] <= wr_data;
    end

    assign rd_vec[g] = mem[rd_addr[IW-1:0]];
  end

  assign rd_data = (rd_addr < DEPTH_B) ? rd_vec[rd_space] : 8'h00;

  assert_wr_in_range_R8: assert property (@(posedge clk) wr_en |-> (wr_addr < DEPTH_B))
    else $error("write strobe for an address outside the bank");

endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
  import i2c_rf_pkg::*;
#(
  parameter int unsigned DEPTH  = 48,
  parameter logic [6:0]  ID_CSR = 7'b1101111,
  parameter logic [6:0]  ID_USR = 7'b1010111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       rd_space,
  output logic [7:0] rd_addr,
  output logic       wr_en,
  output logic       wr_space,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       sda_drv
);

  localparam logic [7:0] LAST_LOC = 8'(DEPTH - 1);
  localparam logic [7:0] DEPTH_B  = 8'(DEPTH);

  phase_t     phase;
  phase_t     nxt_phase;
  logic [3:0] bitcnt;
  logic [6:0] shreg;
  logic [7:0] txsh;
  logic [7:0] ptr;
  logic       space;
  logic [6:0] last_id;
  logic       addr_seen;
  logic       ack_pend;

  // named internal events
  logic       active;
  logic [7:0] byte_in;
  logic       byte_done;
  logic       rd_ack_slot;
  logic       id_ok;
  logic [2:0] tx_idx;

  assign active      = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign byte_in     = {shreg, sda_s};
  assign byte_done   = scl_rise && (bitcnt == 4'd7) &&
                       ((phase == PH_ID) || (phase == PH_ADDR) || (phase == PH_WDATA));
  assign rd_ack_slot = scl_rise && (bitcnt == 4'd8) && (phase == PH_RDATA);
  assign id_ok       = id_accept(byte_in, addr_seen, last_id, ID_CSR, ID_USR);
  assign tx_idx      = 3'd7 - bitcnt[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      nxt_phase <= PH_SKIP;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      space     <= 1'b0;
      last_id   <= '0;
      addr_seen <= 1'b0;
      ack_pend  <= 1'b0;
      sda_drv   <= 1'b0;
    end else if (start_det) begin
      phase    <= PH_ID;
      bitcnt   <= '0;
      sda_drv  <= 1'b0;
      ack_pend <= 1'b0;
      if (phase == PH_IDLE) addr_seen <= 1'b0;
    end else if (stop_det) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      sda_drv   <= 1'b0;
      ack_pend  <= 1'b0;
      addr_seen <= 1'b0;
    end else begin
      if (scl_rise && active) begin
        if (bitcnt < 4'd8) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
        end
      end

      if (byte_done) begin
        unique case (phase)
          PH_ID: begin
            if (id_ok) begin
              ack_pend  <= 1'b1;
              space     <= (byte_in[7:1] == ID_USR);
              last_id   <= byte_in[7:1];
              nxt_phase <= byte_in[0] ? PH_RDATA : PH_ADDR;
            end else begin
              ack_pend  <= 1'b0;
              nxt_phase <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            ptr       <= byte_in;
            addr_seen <= 1'b1;
            ack_pend  <= 1'b1;
            nxt_phase <= PH_WDATA;
          end
          PH_WDATA: begin
            ptr       <= ptr_next(ptr, LAST_LOC);
            ack_pend  <= 1'b1;
            nxt_phase <= PH_SKIP;
          end
          default: ;
        endcase
      end

      if (rd_ack_slot) begin
        ptr       <= ptr_next(ptr, LAST_LOC);
        nxt_phase <= sda_s ? PH_SKIP : PH_RDATA;
      end

      if (scl_fall) begin
        if (!active) begin
          sda_drv <= 1'b0;
        end else if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          phase    <= nxt_phase;
          ack_pend <= 1'b0;
          if (nxt_phase == PH_RDATA) begin
            txsh    <= rd_data;
            sda_drv <= ~rd_data[7];
          end else begin
            sda_drv <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          sda_drv <= ack_pend;
        end else if ((phase == PH_RDATA) && (bitcnt != 4'd0)) begin
          sda_drv <= ~txsh[tx_idx];
        end else begin
          sda_drv <= 1'b0;
        end
      end
    end
  end

  assign wr_en    = byte_done && (phase == PH_WDATA) && (ptr < DEPTH_B);
  assign wr_space = space;
  assign wr_addr  = ptr;
  assign wr_data  = byte_in;
  assign rd_space = space;
  assign rd_addr  = ptr;

  assert_drive_rise_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drv) |-> !scl_s)
    else $error("SDA drive asserted while SCL high");

  assert_drive_fall_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drv) |-> !scl_s)
    else $error("SDA drive released while SCL high");

  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |-> !sda_drv)
    else $error("SDA driven while ignoring the bus");

  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack_slot |=> (ptr < DEPTH_B))
    else $error("pointer left the bank after a read step");

  assert_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> ((bitcnt == 4'd0) && (phase == PH_ID) && !sda_drv))
    else $error("START did not restart the byte");

  assert_bitcnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd9)
    else $error("bit counter out of range");

endmodule

// File: rtl/i2c_dual_regfile.sv
module i2c_dual_regfile #(
  parameter int unsigned DEPTH       = 48,
  parameter logic [6:0]  ID_CSR      = 7'b1101111,
  parameter logic [6:0]  ID_USR      = 7'b1010111,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;
  logic       rd_space;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       wr_en;
  logic       wr_space;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_rf_ctrl #(.DEPTH(DEPTH), .ID_CSR(ID_CSR), .ID_USR(ID_USR)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_space  (rd_space),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_space  (wr_space),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_drv   (sda_oe)
  );

  i2c_rf_bank #(.DEPTH(DEPTH)) u_bank (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_space (wr_space),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_space (rd_space),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

endmodule

// File: tb/i2c_dual_regfile_bench.sv
module i2c_dual_regfile_bench;

  localparam int Q = 8;
  localparam logic [6:0] ID_C = 7'b1101111;
  localparam logic [6:0] ID_U = 7'b1010111;

  // {space(1=user), address, data}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'h11}, {1'b0, 8'h01, 8'h22}, {1'b0, 8'h2E, 8'hA5},
    {1'b0, 8'h2F, 8'h5A}, {1'b1, 8'h00, 8'hC3}, {1'b1, 8'h2F, 8'h3C},
    {1'b1, 8'h10, 8'h81}, {1'b0, 8'h10, 8'h7E}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n  = 1'b0;
  logic scl    = 1'b1;
  logic tb_low = 1'b0;
  wire  sda_oe;
  wire  sda_line = ~(tb_low | sda_oe);

  i2c_dual_regfile u_i2c_dual_regfile (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int   checks = 0;
  int   fails  = 0;
  int   viol   = 0;
  logic last_rel;
  logic [7:0] rbuf [8];
  logic oe_q = 1'b0;
  logic scl_q = 1'b1;

  // R10 monitor: drive may not change while bench SCL stays high
  always @(posedge clk) begin
    if (rst_n && scl && scl_q && (sda_oe != oe_q)) viol++;
    oe_q  <= sda_oe;
    scl_q <= scl;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    tb_low = 1'b0; w(Q);
    scl = 1'b1;    w(Q);
    tb_low = 1'b1; w(Q);
    scl = 1'b0;    w(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0;
    tb_low = 1'b1; w(Q);
    scl = 1'b1;    w(Q);
    tb_low = 1'b0; w(2*Q);
  endtask

  task automatic clock_bit(input logic drive_low, output logic seen);
    tb_low = drive_low; w(Q);
    scl = 1'b1;         w(Q);
    seen = sda_line;    w(Q);
    scl = 1'b0;         w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(~b[i], s);
    clock_bit(1'b0, s);
    acked    = ~s;
    last_rel = ~sda_oe;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b0, s);
      b = {b[6:0], s};
    end
    clock_bit(ack, s);
  endtask

  function automatic logic [6:0] id_of(input logic sp);
    return sp ? ID_U : ID_C;
  endfunction

  task automatic wr_txn(input logic sp, input logic [7:0] a, input logic [7:0] d,
                        output logic all_ack);
    logic a1, a2, a3;
    bus_start();
    send_byte({id_of(sp), 1'b0}, a1);
    send_byte(a, a2);
    send_byte(d, a3);
    bus_stop();
    all_ack = a1 & a2 & a3;
  endtask

  task automatic rd_rand(input logic sp, input logic [7:0] a, input int n,
                         output logic all_ack);
    logic a1, a2, a3;
    logic [7:0] b;
    bus_start();
    send_byte({id_of(sp), 1'b0}, a1);
    send_byte(a, a2);
    bus_start();
    send_byte({id_of(sp), 1'b1}, a3);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      rbuf[k] = b;
    end
    bus_stop();
    all_ack = a1 & a2 & a3;
  endtask

  task automatic rd_cur(input logic sp, input int n, output logic acked);
    logic [7:0] b;
    bus_start();
    send_byte({id_of(sp), 1'b1}, acked);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      rbuf[k] = b;
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic ok, s;
    w(5);
    chk("R1 sda released in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    w(5);

    // table of writes, then random read-back of every entry (R2, R4, R5)
    foreach (VEC[i]) begin
      wr_txn(VEC[i][16], VEC[i][15:8], VEC[i][7:0], ok);
      chk("R2/R4 write acks", {31'd0, ok}, 32'd1);
    end
    foreach (VEC[i]) begin
      rd_rand(VEC[i][16], VEC[i][15:8], 1, ok);
      chk("R5 random read acks", {31'd0, ok}, 32'd1);
      chk("R2 bank data", {24'd0, rbuf[0]}, {24'd0, VEC[i][7:0]});
    end

    // R1: pointer reset, contents kept
    wr_txn(1'b0, 8'h10, 8'h7E, ok);
    rst_n = 1'b0; w(4); rst_n = 1'b1; w(4);
    rd_cur(1'b0, 2, ok);
    chk("R1 current read ack", {31'd0, ok}, 32'd1);
    chk("R1 first byte at 00h", {24'd0, rbuf[0]}, 32'h11);
    chk("R1 second byte at 01h", {24'd0, rbuf[1]}, 32'h22);

    // R3: unknown identifier
    bus_start();
    send_byte(8'hA0, ok);
    chk("R3 unknown id nack", {31'd0, ok}, 32'd0);
    send_byte(8'h00, ok);
    chk("R3 later byte nack", {31'd0, ok}, 32'd0);
    bus_stop();

    // R5: identifier change across the repeated START
    bus_start();
    send_byte({ID_U, 1'b0}, ok);
    send_byte(8'h00, ok);
    bus_start();
    send_byte({ID_C, 1'b1}, ok);
    chk("R5 mismatched read id nack", {31'd0, ok}, 32'd0);
    bus_stop();

    // R6: sequential read across the wrap
    rd_rand(1'b0, 8'h2E, 4, ok);
    chk("R6 acks", {31'd0, ok}, 32'd1);
    chk("R6 byte 2Eh", {24'd0, rbuf[0]}, 32'hA5);
    chk("R6 byte 2Fh", {24'd0, rbuf[1]}, 32'h5A);
    chk("R6 wrapped 00h", {24'd0, rbuf[2]}, 32'h11);
    chk("R6 wrapped 01h", {24'd0, rbuf[3]}, 32'h22);

    // R7: NACK at 2Fh coincides with the wrap step
    rd_rand(1'b0, 8'h2F, 1, ok);
    chk("R7 byte 2Fh", {24'd0, rbuf[0]}, 32'h5A);
    chk("R7 released after nack", {31'd0, sda_oe}, 32'd0);
    rd_cur(1'b0, 1, ok);
    chk("R7 pointer wrapped to 00h", {24'd0, rbuf[0]}, 32'h11);

    // R4 and R11: second data byte refused
    wr_txn(1'b0, 8'h21, 8'h99, ok);
    bus_start();
    send_byte({ID_C, 1'b0}, ok);
    send_byte(8'h20, ok);
    send_byte(8'h44, ok);
    chk("R11 released after ack", {31'd0, last_rel}, 32'd1);
    send_byte(8'h55, ok);
    chk("R4 second data byte nack", {31'd0, ok}, 32'd0);
    bus_stop();
    rd_rand(1'b0, 8'h20, 2, ok);
    chk("R4 data at 20h", {24'd0, rbuf[0]}, 32'h44);
    chk("R4 21h untouched", {24'd0, rbuf[1]}, 32'h99);

    // R8: address beyond the bank
    wr_txn(1'b0, 8'h30, 8'h66, ok);
    chk("R8 out-of-range write acked", {31'd0, ok}, 32'd1);
    rd_rand(1'b0, 8'h30, 2, ok);
    chk("R8 read at 30h is zero", {24'd0, rbuf[0]}, 32'h00);
    chk("R8 then 00h unchanged", {24'd0, rbuf[1]}, 32'h11);

    // R9: STOP and START in the middle of a byte
    bus_start();
    for (int i = 0; i < 4; i++) clock_bit(~ID_U[6-i], s);
    bus_stop();
    wr_txn(1'b1, 8'h05, 8'h77, ok);
    chk("R9 write after stop abort", {31'd0, ok}, 32'd1);
    bus_start();
    for (int i = 0; i < 3; i++) clock_bit(~ID_U[6-i], s);
    bus_start();
    send_byte({ID_U, 1'b0}, ok);
    chk("R9 id after start abort", {31'd0, ok}, 32'd1);
    send_byte(8'h06, ok);
    send_byte(8'h88, ok);
    bus_stop();
    rd_rand(1'b1, 8'h05, 2, ok);
    chk("R9 data 05h", {24'd0, rbuf[0]}, 32'h77);
    chk("R9 data 06h", {24'd0, rbuf[1]}, 32'h88);

    chk("R10 drive stable while SCL high", viol, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule